// File: doc/BRIEF.md
# Periodic Interrupt Status Unit

This block holds the event status and event mask of a real-time clock's interrupt logic. Single-cycle strobes from the time base (hundredth-second, tenth-second and, when configured, second, minute, hour, day and alarm match) each set their own sticky status bit. A processor reaches the block through one byte-wide register address: a write there loads the event mask, and a read there returns the status byte and empties it in the same access.

Bit 7 of the returned byte is a summary flag that is set whenever a recorded event is also unmasked. A level interrupt request is driven from that summary, gated by a global enable that comes from the clock's command register. The request is a flop output, so it reflects the state the block enters at each clock edge. A parameter removes the slow event bits for builds whose time base only produces the two fast periods.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status and mask are zero, a status read returns 8'h00 and irq_o is low.
- R2: A pulse on evt_tick_i[k] sets status bit k, and the bit stays set until a status read. Bit map: 0 alarm, 1 hundredth-second, 2 tenth-second, 3 second, 4 minute, 5 hour, 6 day.
- R3: A read at address IRQ_ADDR (default 16) returns the status byte on bus_rdata in the same cycle and clears all status bits at the following clock edge.
- R4: Bit 7 of the returned byte is 1 exactly when status bits 6..0 and mask bits 6..0 have at least one set bit in common.
- R5: A write at IRQ_ADDR loads mask bits 6..0 from bus_wdata[6:0], ignores bus_wdata[7], and leaves the status bits unchanged.
- R6: irq_o is registered: after each clock edge it equals the summary condition of R4 for the new state ANDed with irq_en as sampled at that edge, so an enable change shows on irq_o one cycle later.
- R7: An event strobe in the same cycle as a status read is kept: after the read the status holds that event, not zero.
- R8: Events whose mask bit is clear are still recorded in the status byte but do not set bit 7 or irq_o.
- R9: Reads at any other address return 8'h00 and clear nothing; writes at any other address leave the mask unchanged.
- R10: With SLOW_EVENTS = 0 only status bits 1 and 2 can ever be set; strobes on the other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_tick_i | input | 7 | One-cycle event strobes, index equals status bit |
| irq_en | input | 1 | Global interrupt enable from the command register |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational for the current access |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an event strobe landing in exactly the cycle of the clearing read, since the two act on the same status bit at the same edge with opposite intent. The bench drives the second strobe pattern on the read cycle itself, then checks that irq_o stays up for the surviving unmasked event and that a second read returns it. A sweep over all 128 mask values, with arithmetic strobe patterns and the enable toggled mid-sequence, covers the summary flag and gating against a second instance built without the slow events.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
   localparam int EVT_N    = 7;
   localparam int BYTE_W   = 8;
   localparam int SUM_BIT  = 7;
   localparam int EV_ALARM = 0;
   localparam int EV_HSEC  = 1;
   localparam int EV_TSEC  = 2;
   localparam int EV_SEC   = 3;
   localparam int EV_MIN   = 4;
   localparam int EV_HOUR  = 5;
   localparam int EV_DAY   = 6;
   localparam logic [EVT_N-1:0] FAST_EVENTS = (EVT_N'(1) << EV_HSEC) | (EVT_N'(1) << EV_TSEC);
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
   import irq_status_pkg::*;
#(
   parameter bit SLOW_EVENTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] tick_i,
   input  logic             clr_i,
   output logic [EVT_N-1:0] stat_o,
   output logic [EVT_N-1:0] stat_nxt_o
);
   for (genvar k = 0; k < EVT_N; k++) begin : g_bit
      localparam bit KEEP = SLOW_EVENTS || FAST_EVENTS[k];
      if (KEEP) begin : g_live
         logic q;
         logic d;
         assign d = (q & ~clr_i) | tick_i[k];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= d;
         end
         assign stat_o[k]     = q;
         assign stat_nxt_o[k] = d;

         assert_tick_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick_i[k] |=> stat_o[k]);
         assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !tick_i[k]) |=> !stat_o[k]);
         assert_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[k] && !clr_i) |=> stat_o[k]);
      end else begin : g_dead
         assign stat_o[k]     = 1'b0;
         assign stat_nxt_o[k] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
   import irq_status_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [EVT_N-1:0] wdata_i,
   output logic [EVT_N-1:0] mask_o,
   output logic [EVT_N-1:0] mask_nxt_o
);
   logic [EVT_N-1:0] mask_q;

   assign mask_nxt_o = wr_i ? wdata_i : mask_q;
   assign mask_o     = mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= mask_nxt_o;
   end

   assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == $past(wdata_i)));
   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
   import irq_status_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] stat_i,
   input  logic [EVT_N-1:0] mask_i,
   input  logic [EVT_N-1:0] stat_nxt_i,
   input  logic [EVT_N-1:0] mask_nxt_i,
   input  logic             en_i,
   output logic             pend_o,
   output logic             irq_o
);
   logic irq_q;

   assign pend_o = |(stat_i & mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= en_i & |(stat_nxt_i & mask_nxt_i);
   end
   assign irq_o = irq_q;

   assert_irq_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend_o);
   assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !irq_o);
   assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && |(stat_nxt_i & mask_nxt_i)) |=> irq_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_status_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int IRQ_ADDR    = 16,
   parameter bit SLOW_EVENTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [EVT_N-1:0]  evt_tick_i,
   input  logic              irq_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic              irq_o
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(IRQ_ADDR);

   if (ADDR_W < 1 || IRQ_ADDR < 0 || IRQ_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("IRQ_ADDR does not fit in ADDR_W");
   end
   if (SUM_BIT != EVT_N || BYTE_W != EVT_N + 1) begin : g_bad_layout
      $error("status byte layout mismatch");
   end

   logic             hit;
   logic             rd_clr;
   logic             mask_wr;
   logic [EVT_N-1:0] stat;
   logic [EVT_N-1:0] stat_nxt;
   logic [EVT_N-1:0] mask;
   logic [EVT_N-1:0] mask_nxt;
   logic             pend;

   assign hit     = bus_sel && (bus_addr == HIT_ADDR);
   assign rd_clr  = hit && !bus_wr;
   assign mask_wr = hit && bus_wr;

   irq_event_latch #(.SLOW_EVENTS(SLOW_EVENTS)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (evt_tick_i),
      .clr_i     (rd_clr),
      .stat_o    (stat),
      .stat_nxt_o(stat_nxt)
   );

   irq_mask_reg u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (mask_wr),
      .wdata_i   (bus_wdata[EVT_N-1:0]),
      .mask_o    (mask),
      .mask_nxt_o(mask_nxt)
   );

   irq_req_gen u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_i    (stat),
      .mask_i    (mask),
      .stat_nxt_i(stat_nxt),
      .mask_nxt_i(mask_nxt),
      .en_i      (irq_en),
      .pend_o    (pend),
      .irq_o     (irq_o)
   );

   assign bus_rdata = rd_clr ? {pend, stat} : '0;

   logic unused_wd7;
   assign unused_wd7 = bus_wdata[SUM_BIT];

   assert_write_keeps_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr && evt_tick_i == '0) |=> (stat == $past(stat)));
   assert_tick_on_read_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> (stat == $past(evt_tick_i & (SLOW_EVENTS ? {EVT_N{1'b1}} : FAST_EVENTS))));
endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] tick = '0;
   logic       en = 1'b0;
   logic       sel = 1'b0;
   logic       wr = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, rdata_f;
   logic       irq, irq_f;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   localparam logic [6:0] FASTM = 7'b0000110;

   always #5 clk = ~clk;

   irq_status_unit i_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .evt_tick_i(tick), .irq_en(en), .bus_sel(sel),
      .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

   irq_status_unit #(.SLOW_EVENTS(1'b0)) i_irq_status_unit_fast (
      .clk(clk), .rst_n(rst_n), .evt_tick_i(tick), .irq_en(en), .bus_sel(sel),
      .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata_f), .irq_o(irq_f));

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic act(logic s, logic w, logic [4:0] a, logic [7:0] d, logic [6:0] t);
      @(negedge clk);
      sel = s; wr = w; addr = a; wdata = d; tick = t;
      #1;
   endtask

   function automatic logic [7:0] sbyte(logic [6:0] st, logic [6:0] m);
      return {|(st & m), st};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      act(1, 0, 5'd16, 8'h00, 7'h00);
      chk("R1 read after reset", rdata, 8'h00);
      chk("R1 irq after reset", {7'h0, irq}, 8'h00);
      en = 1'b1;
      act(0, 0, 5'd0, 8'h00, 7'h7f);
      act(0, 0, 5'd0, 8'h00, 7'h00);
      chk("R8 R1 irq with zero mask", {7'h0, irq}, 8'h00);
      act(1, 0, 5'd16, 8'h00, 7'h00);
      chk("R8 masked events recorded", rdata, 8'h7f);
      chk("R10 fast build ignores slow strobes", rdata_f, 8'h06);

      for (int i = 0; i < 128; i++) begin
         logic [6:0] m, t, u;
         logic       e;
         m = 7'(i);
         t = 7'((i * 53 + 11) & 127);
         u = (i % 3 == 0) ? 7'((i * 29 + 3) & 127) : 7'h00;
         e = i[1];
         en = e;
         act(1, 1, 5'd16, {1'b0, m}, 7'h00);
         act(0, 0, 5'd0, 8'h00, t);
         act(0, 0, 5'd0, 8'h00, 7'h00);
         chk("R6 R2 irq after tick", {7'h0, irq}, {7'h0, (|(t & m)) & e});
         chk("R10 fast irq after tick", {7'h0, irq_f}, {7'h0, (|(t & FASTM & m)) & e});
         en = !e;
         act(1, 1, 5'd17, {1'b1, ~m}, 7'h00);
         chk("R6 enable change one cycle later", {7'h0, irq}, {7'h0, (|(t & m)) & !e});
         en = e;
         act(1, 0, 5'd3, 8'h00, 7'h00);
         chk("R9 read other address", rdata, 8'h00);
         chk("R6 enable restored", {7'h0, irq}, {7'h0, (|(t & m)) & e});
         act(1, 1, 5'd16, {1'b1, m}, 7'h00);
         act(1, 0, 5'd16, 8'h00, u);
         chk("R3 R4 R5 R9 status byte", rdata, sbyte(t, m));
         chk("R10 fast status byte", rdata_f, sbyte(t & FASTM, m));
         act(0, 0, 5'd0, 8'h00, 7'h00);
         chk("R7 irq from tick during read", {7'h0, irq}, {7'h0, (|(u & m)) & e});
         act(1, 0, 5'd16, 8'h00, 7'h00);
         chk("R7 tick during read kept", rdata, sbyte(u, m));
         chk("R10 fast tick during read", rdata_f, sbyte(u & FASTM, m));
         act(0, 0, 5'd0, 8'h00, 7'h00);
         chk("R3 irq low after clearing read", {7'h0, irq}, 8'h00);
         act(1, 0, 5'd16, 8'h00, 7'h00);
         chk("R3 status empty after read", rdata, 8'h00);
      end
      act(0, 0, 5'd0, 8'h00, 7'h00);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule